// File: doc/BRIEF.md
# Resume-Well Reset Generator

This block produces the active-low reset for a resume power well. Its only functional input is a digital indication that the standby supply is above its trip point. That indication stands for an ideal comparator, with any hysteresis or output level handled elsewhere. Reset is held until the supply indication has stayed high for a fixed delay, nominally 32 ms. The delay is measured from the moment the supply crosses the trip point, not from the start of the ramp.

The behaviour is deliberately asymmetric. Release waits for the delay counter to finish. Assertion is combinational from the supply input, so it needs no clock edge. Any dip below the trip point, however short, discards the progress made so far. The whole delay is then served again once the supply recovers, which covers brownouts.

The delay is configured as a clock rate in kHz and a delay in ms. Integrators choose these so the result lies within the allowed 4 ms to 100 ms window. The block runs from a free-running reference clock. A synchronous active-low reset forces the output low and restarts the count.

Top module: `resume_rst_gen`

## Requirements
- R1: While `rst_n` is low the output `rsm_rst_n` is low whatever `supply_ok` does, and it stays low until the full delay has been served after `rst_n` returns high.
- R2: The output never goes high before DELAY_CYCLES rising clock edges have sampled `supply_ok` high without interruption; after DELAY_CYCLES-1 such edges it is still low.
- R3: The output goes high right after the DELAY_CYCLES-th rising clock edge. That count starts at the first edge that samples both `supply_ok` and `rst_n` high.
- R4: When `supply_ok` falls, `rsm_rst_n` goes low in the same clock period, without waiting for a clock edge.
- R5: A dip of `supply_ok` of any length, including one shorter than a clock period that falls between two edges, restarts the full delay.
- R6: Once released, the output stays high for as long as `supply_ok` and `rst_n` stay high.
- R7: DELAY_CYCLES equals CLK_KHZ multiplied by DELAY_MS, so for example 10 kHz and 5 ms give 50 cycles.
- R8: A drop of `supply_ok` part-way through a count discards the cycles already counted. The output is not released at the end of the original window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock that times the release delay |
| rst_n | input | 1 | Synchronous active-low reset; forces reset output low and clears the count |
| supply_ok | input | 1 | High while the standby supply is above its trip point; asynchronous |
| rsm_rst_n | output | 1 | Active-low resume-well reset |

## Verification
A wrong count state shows as a release that comes early or late, and it shows at the first edge where the two disagree. It is measured in whole clock edges from the supply crossing, so the bench samples exactly one cycle before and at the expected release. A completion flag left set after a dip would let the output return high as soon as the supply recovers. The glitch and mid-count drop cases expose that within one clock period. A missing combinational path on assertion would leave the output high for up to a full period after the supply falls, which is visible one nanosecond after the drop.

// File: rtl/rwr_pkg.sv
// Shared constants and helpers for the resume-well reset generator.
// Assumes the delay is expressed as clock kHz times milliseconds.
package rwr_pkg;

    localparam int unsigned RWR_SYNC_STAGES_DEFAULT = 2;

    // Number of reference-clock cycles that make up the release delay.
    function automatic int unsigned rwr_delay_cycles(input int unsigned clk_khz,
                                                     input int unsigned delay_ms);
        return clk_khz * delay_ms;
    endfunction

endpackage

// File: rtl/rwr_sync.sv
// Synchronises the rising edge of an asynchronous supply-good level into
// the clock domain. The chain is cleared asynchronously the moment the
// supply-good level drops, so no dip is missed, and it fills with ones on
// successive edges once the level is high again.
// Assumes STAGES >= 1.
module rwr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_n,
    output logic level_q
);

    generate
        if (STAGES == 1) begin : g_single
            logic stage_q;
            // Single-stage capture of the supply-good level.
            always_ff @(posedge clk or negedge arm_n) begin
                if (!arm_n) begin
                    stage_q <= 1'b0;
                end else if (!rst_n) begin
                    stage_q <= 1'b0;
                end else begin
                    stage_q <= 1'b1;
                end
            end
            assign level_q = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            // Shift ones in while the supply is good; clear at once on a dip.
            always_ff @(posedge clk or negedge arm_n) begin
                if (!arm_n) begin
                    chain_q <= '0;
                end else if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], 1'b1};
                end
            end
            assign level_q = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/rwr_delay.sv
// Counts clock cycles while the synchronised supply-good level is high and
// raises a completion flag after TERM cycles. Both the count and the flag
// clear asynchronously on a supply dip and synchronously when the
// synchronised level is low or rst_n is low.
// Assumes TERM >= 1.
module rwr_delay #(
    parameter int unsigned TERM = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_n,
    input  logic run,
    output logic done
);

    localparam int unsigned CW = (TERM < 2) ? 1 : $clog2(TERM + 1);
    localparam logic [CW-1:0] LAST = CW'(TERM - 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    // Advance the count until the terminal value, then hold the flag.
    always_ff @(posedge clk or negedge arm_n) begin
        if (!arm_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!rst_n || !run) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
                done_q <= 1'b1;
            end
        end
    end

    assign done = done_q;

endmodule

// File: rtl/resume_rst_gen.sv
// Resume-well reset generator. Holds rsm_rst_n low until supply_ok has been
// high for DELAY_CYCLES reference-clock edges, counted from the first edge
// that sees it high. Reasserts combinationally on any drop of supply_ok and
// restarts the full delay. The synchroniser latency is subtracted from the
// counter terminal so that the total matches DELAY_CYCLES exactly.
// Assumes DELAY_CYCLES > SYNC_STAGES.
module resume_rst_gen #(
    parameter int unsigned CLK_KHZ     = 1000,
    parameter int unsigned DELAY_MS    = 32,
    parameter int unsigned SYNC_STAGES = rwr_pkg::RWR_SYNC_STAGES_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    output logic rsm_rst_n
);

    localparam int unsigned DELAY_CYCLES = rwr_pkg::rwr_delay_cycles(CLK_KHZ, DELAY_MS);
    localparam int unsigned COUNT_TERM   = DELAY_CYCLES - SYNC_STAGES;

    logic supply_sync;
    logic released;

    rwr_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_n   (supply_ok),
        .level_q (supply_sync)
    );

    rwr_delay #(
        .TERM (COUNT_TERM)
    ) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .arm_n (supply_ok),
        .run   (supply_sync),
        .done  (released)
    );

    // Release needs the finished count; assertion follows the supply at once.
    assign rsm_rst_n = released & supply_ok;

endmodule

// File: rtl/resume_rst_gen_chk.sv
// Checker for resume_rst_gen. Keeps its own count of edges that sampled the
// supply good (cleared at once on any dip) and relates the reset output to it.
module resume_rst_gen_chk #(
    parameter int unsigned DELAY_CYCLES = 32
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic rsm_rst_n
);

    localparam int unsigned CW = $clog2(DELAY_CYCLES + 1) + 1;
    localparam logic [CW-1:0] FULL = CW'(DELAY_CYCLES);

    logic [CW-1:0] good_edges;

    // Saturating count of good-supply edges since the last dip or reset.
    always_ff @(posedge clk or negedge supply_ok) begin
        if (!supply_ok) begin
            good_edges <= '0;
        end else if (!rst_n) begin
            good_edges <= '0;
        end else if (good_edges < FULL) begin
            good_edges <= good_edges + 1'b1;
        end
    end

    assert_not_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsm_rst_n |-> (good_edges >= FULL));

    assert_not_late_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((good_edges >= FULL) && supply_ok) |-> rsm_rst_n);

    assert_restart_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsm_rst_n) |-> (good_edges == FULL));

    assert_stays_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsm_rst_n && (good_edges >= FULL)) |=> (rsm_rst_n || (good_edges < FULL)));

endmodule

bind resume_rst_gen resume_rst_gen_chk #(
    .DELAY_CYCLES (DELAY_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .rsm_rst_n (rsm_rst_n)
);

// File: tb/test_resume_rst_gen.sv
// Directed bench for resume_rst_gen: one task per scenario.
module test_resume_rst_gen;

    localparam int unsigned KHZ = 10;
    localparam int unsigned MS  = 5;
    localparam int unsigned D   = KHZ * MS; // R7: 10 kHz * 5 ms = 50 cycles

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic rsm_rst_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    resume_rst_gen #(
        .CLK_KHZ  (KHZ),
        .DELAY_MS (MS)
    ) i_resume_rst_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .rsm_rst_n (rsm_rst_n)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Called right after the first counting edge's setup: D-1 edges low, D-th releases.
    task automatic expect_release(input string tag);
        repeat (D - 1) @(posedge clk);
        @(negedge clk);
        check(rsm_rst_n, 1'b0, {tag, " R2 still low after D-1 edges"});
        @(posedge clk);
        @(negedge clk);
        check(rsm_rst_n, 1'b1, {tag, " R3 R7 released at edge D"});
    endtask

    task automatic t_reset_state();
        supply_ok = 1'b1;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check(rsm_rst_n, 1'b0, "R1 low during reset");
        supply_ok = 1'b0;
        @(negedge clk);
        supply_ok = 1'b1;
        repeat (3) @(negedge clk);
        check(rsm_rst_n, 1'b0, "R1 low during reset with supply toggling");
        rst_n = 1'b1;
        expect_release("R1 after reset release");
    endtask

    task automatic t_drop_immediate();
        @(negedge clk);
        #2 supply_ok = 1'b0;
        #1 check(rsm_rst_n, 1'b0, "R4 low without clock edge");
        repeat (3) @(negedge clk);
        check(rsm_rst_n, 1'b0, "R4 held low while supply low");
        supply_ok = 1'b1;
        expect_release("R5 recovery");
    endtask

    task automatic t_short_glitch();
        @(negedge clk);
        supply_ok = 1'b0;
        #2 supply_ok = 1'b1;
        #1 check(rsm_rst_n, 1'b0, "R5 low after sub-cycle glitch");
        expect_release("R5 glitch restart");
    endtask

    task automatic t_drop_midcount();
        @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        supply_ok = 1'b1;
        repeat (30) @(posedge clk);
        @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        supply_ok = 1'b1;
        repeat (D - 30) @(negedge clk);
        check(rsm_rst_n, 1'b0, "R8 not released at original window end");
        supply_ok = 1'b0;
        @(negedge clk);
        supply_ok = 1'b1;
        expect_release("R8 full delay after mid-count drop");
    endtask

    task automatic t_stable();
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            check(rsm_rst_n, 1'b1, "R6 stays released");
        end
    endtask

    task automatic t_reset_midrun();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(rsm_rst_n, 1'b0, "R1 reset after release");
        rst_n = 1'b1;
        expect_release("R1 re-release");
    endtask

    initial begin
        t_reset_state();
        t_stable();
        t_drop_immediate();
        t_short_glitch();
        t_drop_midcount();
        t_reset_midrun();
        t_stable();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule